// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

This block sits between a 32-bit core-side request port and an external bus whose responder may narrow any cycle to 8 or 16 bits. The core presents one request at a time. A request carries active-low byte enables (one per byte lane, lane 0 on bits 7:0 and lane 3 on bits 31:24), a write flag, an address and write data. The sequencer then runs as many bus cycles as the responder's size answers require. Each cycle keeps the request address, and the byte enables shrink from one cycle to the next.

At the end of each bus cycle, marked by ready, the sequencer reads two active-low size inputs. From them it computes the byte enables of the following cycle, or it decides that the transfer is finished. On reads, the bytes returned on the lanes that the cycle actually delivered are stored into a 32-bit holding register at their natural positions. The assembled word is presented together with a single-cycle done pulse.

Top module: `bus_size_seq`

## Requirements
- R1: During and after reset, with no request pending, `bus_cyc` is 0, `bus_be_n` is 4'b1111 and `done` is 0.
- R2: A request is taken when `req_valid` is high and no transfer is running. From the next cycle, `bus_cyc` is 1 and the bus shows the request's enables, address and write flag. A `req_valid` seen while a transfer runs is ignored.
- R3: Within a transfer, `bus_be_n`, `bus_addr`, `bus_write` and `bus_wdata` change only after a clock edge where `bus_rdy` is 1. The size inputs have no effect in cycles without `bus_rdy`.
- R4: When `bus_sz8_n` is 0 at ready, the next enables are the current ones with the lowest asserted lane removed. This rule holds even if `bus_sz16_n` is also 0. The transfer ends if no lane remains.
- R5: When only `bus_sz16_n` is 0 at ready, the next cycle depends on whether lane 0 or lane 1 is asserted. If either is, the next cycle keeps only the asserted lanes among 2 and 3, and the transfer ends if there are none. If neither lane 0 nor lane 1 is asserted, the transfer ends.
- R6: When neither size input is 0 at ready, or when exactly one lane is enabled, the transfer ends at that ready.
- R7: Which lanes a read cycle captures depends on the size answer:
  - At full width, every asserted lane is captured.
  - At 8-bit size, only the lowest asserted lane is captured.
  - At 16-bit size, if lane 0 or lane 1 is asserted, the asserted lanes among 0 and 1 are captured. Otherwise the asserted lanes among 2 and 3 are captured.
- R8: A captured byte is written into the holding register at its own lane position. Lanes not captured keep their previous value. `rdata` shows the holding register, and it is valid while `done` is 1.
- R9: During a bus cycle, `bus_wdata` carries the request byte on each asserted lane at its natural position, and 0 on each deasserted lane.
- R10: `done` is 1 for exactly one cycle: the cycle after the ready that ends the transfer. In that cycle `bus_cyc` is 0.
- R11: A request whose enables are all 4'b1111 produces `done` in the next cycle, and no bus cycle is run for it.
- R12: Over one transfer, every requested byte lane is moved in exactly one bus cycle, and no unrequested lane is moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_be_n | input | 4 | Request byte enables, active low, bit i is lane i |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request address |
| req_wdata | input | 32 | Request write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word (holding register) |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_be_n | output | 4 | Bus byte enables, active low |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 32 | Bus write data, masked to asserted lanes |
| bus_rdy | input | 1 | Responder ends the current cycle |
| bus_sz8_n | input | 1 | Responder answers 8-bit width, active low |
| bus_sz16_n | input | 1 | Responder answers 16-bit width, active low |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
The bound checker watches for rule violations on every cycle:
- bus signals that move during a wait,
- enables that fail to shrink strictly after a ready,
- a transfer that keeps running after a single-lane cycle or after a cycle with no size answer,
- lower lanes that are still enabled after a 16-bit answer,
- write lanes that are not zeroed,
- a done pulse that overlaps a bus cycle.

The exact next-enable tables, the lanes captured per size, the merging into the holding register and the once-only transfer of each byte are checked only by the bench's reference model. That model runs under a responder that picks the size at random or forces it.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [0:0] {ST_IDLE, ST_BUS} seq_st_t;

  // Expand an active-high lane set into a bit mask over the data word.
  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] lanes);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{lanes[i]}};
    return m;
  endfunction
endpackage

// File: rtl/bsz_next_be.sv
module bsz_next_be
  import bsz_pkg::*;
(
  input  logic [LANES-1:0] be_n,
  input  logic             sz8_n,
  input  logic             sz16_n,
  output logic [LANES-1:0] nxt_be_n,
  output logic             last
);
  logic [LANES-1:0] act, low, keep;

  always_comb begin
    act = ~be_n;
    low = act & (~act + 1'b1);
    if (!sz8_n)
      keep = act & ~low;
    else if (!sz16_n)
      keep = (act[1:0] != 2'b00) ? (act & 4'b1100) : '0;
    else
      keep = '0;
    nxt_be_n = ~keep;
    last     = (keep == '0);
  end
endmodule

// File: rtl/bsz_lane_pick.sv
module bsz_lane_pick
  import bsz_pkg::*;
(
  input  logic [LANES-1:0] be_n,
  input  logic             sz8_n,
  input  logic             sz16_n,
  output logic [LANES-1:0] take
);
  logic [LANES-1:0] act;

  always_comb begin
    act = ~be_n;
    if (!sz8_n)
      take = act & (~act + 1'b1);
    else if (!sz16_n)
      take = (act[1:0] != 2'b00) ? (act & 4'b0011) : (act & 4'b1100);
    else
      take = act;
  end
endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
  import bsz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [3:0]    req_be_n,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_cyc,
  output logic [3:0]    bus_be_n,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_rdy,
  input  logic          bus_sz8_n,
  input  logic          bus_sz16_n,
  input  logic [31:0]   bus_rdata
);
  seq_st_t          st_q;
  logic [LANES-1:0] be_q, nxt_be_n, take;
  logic             last, wr_q, done_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wd_q;
  logic [7:0]       hold_b [LANES];
  logic             end_cyc;

  bsz_next_be u_next (
    .be_n(be_q), .sz8_n(bus_sz8_n), .sz16_n(bus_sz16_n),
    .nxt_be_n(nxt_be_n), .last(last)
  );

  bsz_lane_pick u_pick (
    .be_n(be_q), .sz8_n(bus_sz8_n), .sz16_n(bus_sz16_n), .take(take)
  );

  assign end_cyc = (st_q == ST_BUS) && bus_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      be_q   <= '1;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          if (&req_be_n) begin
            done_q <= 1'b1;
          end else begin
            st_q   <= ST_BUS;
            be_q   <= req_be_n;
            wr_q   <= req_write;
            addr_q <= req_addr;
            wd_q   <= req_wdata & lane_mask(~req_be_n);
          end
        end
        ST_BUS: if (bus_rdy) begin
          if (last) begin
            st_q   <= ST_IDLE;
            be_q   <= '1;
            done_q <= 1'b1;
          end else begin
            be_q <= nxt_be_n;
            wd_q <= wd_q & lane_mask(~nxt_be_n);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // One byte register per lane for the read holding word.
  for (genvar g = 0; g < LANES; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold_b[g] <= '0;
      else if (end_cyc && !wr_q && take[g])
        hold_b[g] <= bus_rdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = hold_b[g];
  end

  assign done      = done_q;
  assign bus_cyc   = (st_q == ST_BUS);
  assign bus_be_n  = be_q;
  assign bus_write = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wd_q;
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker
  import bsz_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          bus_cyc,
  input logic [3:0]    bus_be_n,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_rdy,
  input logic          bus_sz8_n,
  input logic          bus_sz16_n
);
  AST_IDLE_BE: assert property (@(posedge clk) disable iff (rst)
    !bus_cyc |-> bus_be_n == 4'hF); // R1

  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && !bus_rdy |=> bus_cyc && $stable(bus_be_n) && $stable(bus_addr)
      && $stable(bus_write) && $stable(bus_wdata)); // R3

  AST_BE_SHRINK: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_rdy |=> !bus_cyc ||
      (((~bus_be_n) & $past(bus_be_n)) == 4'h0 && bus_be_n != $past(bus_be_n))); // R4

  AST_SZ16_UPPER: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_rdy && bus_sz8_n && !bus_sz16_n |=> !bus_cyc || bus_be_n[1:0] == 2'b11); // R5

  AST_SINGLE_END: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_rdy && $countones(~bus_be_n) == 1 |=> done && !bus_cyc); // R6

  AST_NOSIZE_END: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_rdy && bus_sz8_n && bus_sz16_n |=> done); // R6

  AST_WMASK: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> (bus_wdata & ~lane_mask(~bus_be_n)) == 32'h0); // R9

  AST_DONE_NO_CYC: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_cyc); // R10
endmodule

bind bus_size_seq bsz_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .bus_cyc(bus_cyc), .bus_be_n(bus_be_n),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdy(bus_rdy), .bus_sz8_n(bus_sz8_n), .bus_sz16_n(bus_sz16_n)
);

// File: tb/bus_size_seq_tb_top.sv
module bus_size_seq_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]    req_be_n = 4'hF;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          done, bus_cyc, bus_write;
  logic [31:0]   rdata, bus_wdata;
  logic [3:0]    bus_be_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rdy = 1'b0, bus_sz8_n = 1'b1, bus_sz16_n = 1'b1;
  logic [31:0]   bus_rdata = '0;

  bus_size_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_be_n(req_be_n),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_be_n(bus_be_n),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdy(bus_rdy), .bus_sz8_n(bus_sz8_n), .bus_sz16_n(bus_sz16_n),
    .bus_rdata(bus_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // Reference model state
  bit          m_busy = 0, m_wr = 0, exp_done = 0;
  logic [3:0]  m_be = 4'hF, m_req = 4'h0;
  logic [31:0] m_addr = '0, m_wd = '0, m_hold = '0;
  int          cnt [4];
  int          force_sz = 0; // 0 random, 1 full, 2 8-bit, 3 16-bit, 4 both asserted

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] act);
    for (int i = 0; i < 4; i++) if (act[i]) return i;
    return 4;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] act);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (act[i]) m = m | (32'hFF << (8 * i));
    return m;
  endfunction

  function automatic logic [3:0] ref_take(input logic [3:0] be_n, input logic s8n, input logic s16n);
    logic [3:0] act = ~be_n;
    int lo = lowest(act);
    if (!s8n) return 4'(1 << lo);
    if (!s16n) return (lo < 2) ? (act & 4'b0011) : (act & 4'b1100);
    return act;
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] be_n, input logic s8n, input logic s16n);
    logic [3:0] act = ~be_n;
    int lo = lowest(act);
    if (!s8n) act[lo] = 1'b0;
    else if (!s16n) act = (lo < 2) ? (act & 4'b1100) : 4'b0000;
    else act = 4'b0000;
    return ~act;
  endfunction

  task automatic step();
    logic [3:0] tk, nx;
    @(posedge clk);
    exp_done = 0;
    if (!m_busy) begin
      if (req_valid) begin
        if (req_be_n == 4'hF) exp_done = 1;
        else begin
          m_busy = 1; m_be = req_be_n; m_addr = req_addr; m_wr = req_write;
          m_wd = req_wdata; m_req = ~req_be_n;
          for (int i = 0; i < 4; i++) cnt[i] = 0;
        end
      end
    end else if (bus_rdy) begin
      tk = ref_take(m_be, bus_sz8_n, bus_sz16_n);
      for (int i = 0; i < 4; i++) if (tk[i]) begin
        cnt[i]++;
        if (!m_wr) m_hold[8*i +: 8] = bus_rdata[8*i +: 8];
      end
      nx = ref_next(m_be, bus_sz8_n, bus_sz16_n);
      if (nx == 4'hF) begin
        m_busy = 0; exp_done = 1; m_be = 4'hF;
        for (int i = 0; i < 4; i++)
          chk(cnt[i] == (m_req[i] ? 1 : 0), "R12 lane moved exactly once", cnt[i], m_req[i]);
      end else m_be = nx;
    end
    @(negedge clk);
    chk(bus_cyc == m_busy, "R2/R10 bus_cyc", bus_cyc, m_busy);
    chk(bus_be_n == m_be, "R4/R5/R6 bus_be_n", bus_be_n, m_be);
    if (m_busy) begin
      chk(bus_addr == m_addr && bus_write == m_wr, "R2/R3 addr/write", bus_addr, m_addr);
      chk(bus_wdata == (m_wd & bytes_of(~m_be)), "R9 wdata lanes", bus_wdata, m_wd & bytes_of(~m_be));
    end
    chk(done == exp_done, "R10/R11 done", done, exp_done);
    if (exp_done) chk(rdata == m_hold, "R7/R8 rdata", rdata, m_hold);
    // Responder: sizes are random even without ready (R3: ignored then)
    bus_rdata = $urandom;
    bus_rdy = m_busy && (($urandom % 3) != 0);
    bus_sz8_n = $urandom % 2; bus_sz16_n = $urandom % 2;
    if (bus_rdy) begin
      case (force_sz)
        1: begin bus_sz8_n = 1; bus_sz16_n = 1; end
        2: begin bus_sz8_n = 0; bus_sz16_n = 1; end
        3: begin bus_sz8_n = 1; bus_sz16_n = 0; end
        4: begin bus_sz8_n = 0; bus_sz16_n = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic issue(input logic [3:0] be, input bit wr, input bit poke_busy);
    while (m_busy) step();
    req_valid = 1; req_be_n = be; req_write = wr;
    req_addr = $urandom; req_wdata = $urandom;
    step();
    req_valid = 0;
    while (m_busy) begin
      if (poke_busy) begin // R2: a request during a transfer must be ignored
        req_valid = 1; req_be_n = 4'h0; req_write = ~wr; req_addr = $urandom;
      end
      step();
    end
    req_valid = 0;
  endtask

  logic [3:0] pats [10] = '{4'hE, 4'hC, 4'h8, 4'h0, 4'hD, 4'h9, 4'h1, 4'hB, 4'h3, 4'h7};

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(bus_cyc == 0 && bus_be_n == 4'hF && done == 0, "R1 reset state", {bus_cyc, bus_be_n, done}, 32'h1E);
    end
    rst = 0;
    step();
    chk(bus_cyc == 0 && done == 0, "R1 idle after reset", {bus_cyc, done}, 0);
    // R11: empty requests
    issue(4'hF, 0, 0);
    issue(4'hF, 1, 0);
    // R4: forced 8-bit, and priority when both asserted
    force_sz = 2; issue(4'h0, 0, 0); issue(4'h8, 1, 0);
    force_sz = 4; issue(4'h1, 0, 0);
    // R5: forced 16-bit
    force_sz = 3; issue(4'h0, 0, 0); issue(4'h3, 0, 0); issue(4'h9, 1, 0); issue(4'h8, 0, 0);
    // R6: full width and single lanes
    force_sz = 1; issue(4'h0, 0, 0); issue(4'hB, 1, 0);
    force_sz = 2; issue(4'h7, 0, 0);
    // R7/R8: narrow read after a wide one keeps the other lanes
    force_sz = 1; issue(4'h0, 0, 0);
    force_sz = 2; issue(4'hD, 0, 0);
    // R2: request strobes during a busy transfer
    force_sz = 0; issue(4'h0, 0, 1); issue(4'h1, 1, 1);
    // Random sweep
    for (int k = 0; k < 400; k++) begin
      force_sz = $urandom % 5;
      issue((($urandom % 12) == 0) ? 4'hF : pats[$urandom % 10], $urandom % 2, ($urandom % 4) == 0);
      if (($urandom % 3) == 0) step();
    end
    repeat (2) step();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", n_chk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end
endmodule